// File: doc/BRIEF.md
# Transfer staging buffer with indexed host port and sequencer byte port

The block holds the data of one flash transfer: 512 bytes kept as 128 words of 32 bits. The host reaches the storage through a control register and one 32-bit data port. The control register sets the transfer direction, turns the automatic index step on or off, and loads the word index. With the direction set to transmit, host writes to the data port fill the buffer. With the direction set to receive, the host reads received data back through the same port. When the automatic step is enabled, each accepted access moves the index on by one word. The index wraps from the last word to word 0.

The command sequencer sees the same storage one byte at a time. A start-offset register sets the byte where it begins. Each sequencer byte access moves its pointer on by one byte. The sequencer owns the storage while its busy input is high, and host data-port accesses are dropped during that time. A transfer whose length is not a multiple of four ends in a word that is only partly used. The host still moves that word as a full 32-bit access, and only its low bytes carry transfer data.

Top module: `sbuf_top`

## Requirements
- R1: After reset, the control readback, the host data word and the start offset are all zero, and every stored byte is zero.
- R2: A control write loads the direction from bit 31, the auto-step enable from bit 30 and the word index from bits 6:0. The same layout reads back on `ctrl_rdata_o`, with all other bits zero.
- R3: With direction 1, a data-port write stores the full 32-bit word at the current index. With direction 0, a data-port write changes no storage and does not move the index.
- R4: `data_rdata_o` always shows the word at the current index. A read strobe with direction 0 is an accepted access. A read strobe with direction 1 does not move the index.
- R5: An accepted data-port access moves the index on by one when auto-step is set, and leaves it unchanged when auto-step is clear. A control write in the same cycle takes precedence.
- R6: The word index wraps from 127 to 0 on an auto-step.
- R7: Bytes are packed little-endian: buffer byte k is bits 8*(k mod 4)+7 down to 8*(k mod 4) of word k/4.
- R8: A start pulse loads the sequencer byte pointer from the start-offset register. Each sequencer read or write while busy moves the pointer on by one byte. `seq_rbyte_o` shows the byte at the pointer. A sequencer write changes only the addressed byte.
- R9: While `seq_busy_i` is high, host data-port writes and reads are ignored: nothing is stored and the index does not move. Sequencer reads and writes made while busy is low are ignored.
- R10: The sequencer byte pointer wraps from byte 511 to byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control write value: bit 31 direction, bit 30 auto-step, bits 6:0 index |
| ctrl_rdata_o | output | 32 | Control register readback |
| data_we_i | input | 1 | Host data-port write strobe |
| data_re_i | input | 1 | Host data-port read strobe; the word is taken in the same cycle |
| data_wdata_i | input | 32 | Host data-port write word |
| data_rdata_o | output | 32 | Word at the current index |
| seq_busy_i | input | 1 | Sequencer owns the storage |
| seq_base_we_i | input | 1 | Start-offset register write strobe |
| seq_base_i | input | 9 | Start byte offset |
| seq_start_i | input | 1 | Load the byte pointer from the start offset |
| seq_we_i | input | 1 | Sequencer byte write strobe |
| seq_re_i | input | 1 | Sequencer byte read strobe |
| seq_wbyte_i | input | 8 | Sequencer write byte |
| seq_rbyte_o | output | 8 | Byte at the sequencer pointer |

## Verification
The bench writes one byte at a time from the sequencer across an unaligned start offset and a word boundary, then reads the words back through the host port. A design with the wrong byte order, or one that writes the whole word on a byte access, shows wrong values in the partly used words. The bench checks the wrap from word 127 and from byte 511. A design that counts past the end instead of wrapping sends those accesses to a different slot. It also makes accesses that must be dropped: data writes with direction 0, read strobes with direction 1, and host accesses while the sequencer is busy. A design that fails to drop them stores stray data or moves the index, and the later readback shows the error.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned LANES       = WORD_W / BYTE_W;
  localparam int unsigned DIR_BIT     = 31;
  localparam int unsigned AUTO_BIT    = 30;

  typedef struct packed {
    logic dir;       // 1: host fills for transmit, 0: host drains receive
    logic auto_inc;
  } host_mode_t;
endpackage

// File: rtl/sbuf_host_idx.sv
module sbuf_host_idx
  import sbuf_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [WORD_W-1:0] ctrl_wdata_i,
  input  logic              data_we_i,
  input  logic              data_re_i,
  input  logic              seq_busy_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              word_we_o,
  output logic [WORD_W-1:0] ctrl_rdata_o
);
  host_mode_t       mode_q;
  logic [IDX_W-1:0] idx_q;
  logic             accept;
  logic             unused_ctrl;

  assign unused_ctrl = ^ctrl_wdata_i[AUTO_BIT-1:IDX_W];

  // sequencer owns the storage while busy
  assign accept    = !seq_busy_i && ((data_we_i && mode_q.dir) || (data_re_i && !mode_q.dir));
  assign word_we_o = !seq_busy_i && data_we_i && mode_q.dir;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      idx_q  <= '0;
    end else if (ctrl_we_i) begin
      mode_q.dir      <= ctrl_wdata_i[DIR_BIT];
      mode_q.auto_inc <= ctrl_wdata_i[AUTO_BIT];
      idx_q           <= ctrl_wdata_i[IDX_W-1:0];
    end else if (accept && mode_q.auto_inc) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    ctrl_rdata_o            = '0;
    ctrl_rdata_o[DIR_BIT]   = mode_q.dir;
    ctrl_rdata_o[AUTO_BIT]  = mode_q.auto_inc;
    ctrl_rdata_o[IDX_W-1:0] = idx_q;
  end

  assign idx_o = idx_q;

  assert_idx_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_we_i && !seq_busy_i && data_we_i && ctrl_rdata_o[DIR_BIT] && ctrl_rdata_o[AUTO_BIT]
     && idx_q == {IDX_W{1'b1}}) |=> (idx_q == '0));

  assert_idx_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_we_i && !ctrl_rdata_o[AUTO_BIT]) |=> $stable(idx_q));

  assert_busy_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_we_i && seq_busy_i) |=> $stable(idx_q));
endmodule

// File: rtl/sbuf_seq_ptr.sv
module sbuf_seq_ptr #(
  parameter int unsigned PTR_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic [PTR_W-1:0] base_i,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic             we_i,
  input  logic             re_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             byte_we_o
);
  logic [PTR_W-1:0] base_q;
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (base_we_i) base_q <= base_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ptr_q <= '0;
    else if (start_i)                ptr_q <= base_q;
    else if (busy_i && (we_i || re_i)) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o     = ptr_q;
  assign byte_we_o = busy_i && we_i;

  assert_start_loads_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !base_we_i) |=> (ptr_q == $past(base_q)));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !busy_i) |=> $stable(ptr_q));

  assert_ptr_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && busy_i && re_i && ptr_q == {PTR_W{1'b1}}) |=> (ptr_q == '0));
endmodule

// File: rtl/sbuf_store.sv
module sbuf_store
  import sbuf_pkg::*;
#(
  parameter int unsigned WORDS = 128,
  parameter int unsigned IDX_W = 7,
  parameter int unsigned PTR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wword_i,
  output logic [WORD_W-1:0] rword_o,
  input  logic              byte_we_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  output logic [BYTE_W-1:0] rbyte_o
);
  localparam int unsigned LANE_W = $clog2(LANES);

  logic [WORD_W-1:0] mem_q [WORDS];
  logic [IDX_W-1:0]  bword;
  logic [LANE_W-1:0] blane;
  logic [WORD_W-1:0] bsel;
  logic [BYTE_W-1:0] lane_bytes [LANES];

  assign bword = ptr_i[PTR_W-1:LANE_W];
  assign blane = ptr_i[LANE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < int'(WORDS); w++) mem_q[w] <= '0;
    end else begin
      if (word_we_i) mem_q[idx_i] <= wword_i;
      if (byte_we_i) mem_q[bword][{blane, 3'b000} +: BYTE_W] <= wbyte_i;
    end
  end

  assign rword_o = mem_q[idx_i];
  assign bsel    = mem_q[bword];

  // little-endian lane split
  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    assign lane_bytes[l] = bsel[l*BYTE_W +: BYTE_W];
  end
  assign rbyte_o = lane_bytes[blane];

  assert_word_stored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_we_i && !byte_we_i) |=> (mem_q[$past(idx_i)] == $past(wword_i)));

  assert_byte_stored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_we_i && !word_we_i) |=> (mem_q[$past(bword)][{$past(blane), 3'b000} +: BYTE_W] == $past(wbyte_i)));
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
  import sbuf_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [31:0] ctrl_wdata_i,
  output logic [31:0] ctrl_rdata_o,
  input  logic        data_we_i,
  input  logic        data_re_i,
  input  logic [31:0] data_wdata_i,
  output logic [31:0] data_rdata_o,
  input  logic        seq_busy_i,
  input  logic        seq_base_we_i,
  input  logic [8:0]  seq_base_i,
  input  logic        seq_start_i,
  input  logic        seq_we_i,
  input  logic        seq_re_i,
  input  logic [7:0]  seq_wbyte_i,
  output logic [7:0]  seq_rbyte_o
);
  localparam int unsigned WORDS = BUF_BYTES / LANES;
  localparam int unsigned IDX_W = $clog2(WORDS);
  localparam int unsigned PTR_W = $clog2(BUF_BYTES);

  logic [IDX_W-1:0] idx;
  logic             word_we;
  logic [PTR_W-1:0] ptr;
  logic             byte_we;

  sbuf_host_idx #(.IDX_W(IDX_W)) u_host (
    .clk_i, .rst_ni,
    .ctrl_we_i, .ctrl_wdata_i,
    .data_we_i, .data_re_i, .seq_busy_i,
    .idx_o(idx), .word_we_o(word_we), .ctrl_rdata_o
  );

  sbuf_seq_ptr #(.PTR_W(PTR_W)) u_seq (
    .clk_i, .rst_ni,
    .base_we_i(seq_base_we_i), .base_i(seq_base_i),
    .start_i(seq_start_i), .busy_i(seq_busy_i),
    .we_i(seq_we_i), .re_i(seq_re_i),
    .ptr_o(ptr), .byte_we_o(byte_we)
  );

  sbuf_store #(.WORDS(WORDS), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_store (
    .clk_i, .rst_ni,
    .word_we_i(word_we), .idx_i(idx), .wword_i(data_wdata_i), .rword_o(data_rdata_o),
    .byte_we_i(byte_we), .ptr_i(ptr), .wbyte_i(seq_wbyte_i), .rbyte_o(seq_rbyte_o)
  );

  assert_one_owner_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy_i |=> $stable(ctrl_rdata_o[6:0]) || $past(ctrl_we_i));
endmodule

// File: tb/sbuf_top_tb_top.sv
module sbuf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic        data_we = 1'b0;
  logic        data_re = 1'b0;
  logic [31:0] data_wdata = '0;
  logic [31:0] data_rdata;
  logic        busy = 1'b0;
  logic        base_we = 1'b0;
  logic [8:0]  base = '0;
  logic        start = 1'b0;
  logic        s_we = 1'b0;
  logic        s_re = 1'b0;
  logic [7:0]  s_wbyte = '0;
  logic [7:0]  s_rbyte;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sbuf_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .data_we_i(data_we), .data_re_i(data_re), .data_wdata_i(data_wdata), .data_rdata_o(data_rdata),
    .seq_busy_i(busy), .seq_base_we_i(base_we), .seq_base_i(base),
    .seq_start_i(start), .seq_we_i(s_we), .seq_re_i(s_re),
    .seq_wbyte_i(s_wbyte), .seq_rbyte_o(s_rbyte)
  );

  // op: 0 ctrl write, 1 data write, 2 check data word then read strobe, 3 check ctrl readback
  localparam logic [37:0] VT [14] = '{
    {2'd0, 32'hC000_0000, 4'd2},  // R2 dir 1, auto, idx 0
    {2'd1, 32'h1111_1111, 4'd3},  // R3
    {2'd1, 32'h2222_2222, 4'd3},
    {2'd1, 32'h3333_3333, 4'd3},
    {2'd3, 32'hC000_0003, 4'd5},  // R5 three steps
    {2'd0, 32'h4000_0000, 4'd2},  // dir 0, auto, idx 0
    {2'd2, 32'h1111_1111, 4'd4},  // R4
    {2'd2, 32'h2222_2222, 4'd4},
    {2'd2, 32'h3333_3333, 4'd4},
    {2'd3, 32'h4000_0003, 4'd5},
    {2'd0, 32'h0000_0001, 4'd2},  // dir 0, no auto, idx 1
    {2'd2, 32'h2222_2222, 4'd5},  // R5 no step
    {2'd2, 32'h2222_2222, 4'd5},
    {2'd3, 32'h0000_0001, 4'd5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [31:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic rd_strobe();
    @(negedge clk); data_re = 1'b1;
    @(negedge clk); data_re = 1'b0;
  endtask

  task automatic seq_pulse(input logic w, input logic [7:0] b);
    @(negedge clk); s_we = w; s_re = ~w; s_wbyte = b;
    @(negedge clk); s_we = 1'b0; s_re = 1'b0;
  endtask

  task automatic set_base(input logic [8:0] b);
    @(negedge clk); base_we = 1'b1; base = b;
    @(negedge clk); base_we = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl_rdata, 32'h0);
    chk("R1 word", data_rdata, 32'h0);
    busy = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R1 offset byte", {24'h0, s_rbyte}, 32'h0);
    busy = 1'b0;

    for (int i = 0; i < 14; i++) begin
      logic [1:0]  op;
      logic [31:0] v;
      logic [3:0]  r;
      string       tag;
      {op, v, r} = VT[i];
      tag = $sformatf("R%0d vec %0d", r, i);
      case (op)
        2'd0: wr_ctrl(v);
        2'd1: wr_data(v);
        2'd2: begin @(negedge clk); chk(tag, data_rdata, v); rd_strobe(); end
        default: begin @(negedge clk); chk(tag, ctrl_rdata, v); end
      endcase
    end

    // R3 write with direction 0 is dropped
    wr_ctrl(32'h4000_0005);
    wr_data(32'hAAAA_AAAA);
    chk("R3 dir0 idx", ctrl_rdata, 32'h4000_0005);
    chk("R3 dir0 word", data_rdata, 32'h0);
    // R4 read strobe with direction 1 does not advance
    wr_ctrl(32'hC000_0005);
    rd_strobe();
    chk("R4 dir1 read", ctrl_rdata, 32'hC000_0005);

    // R6 index wrap
    wr_ctrl(32'hC000_007F);
    wr_data(32'hDEAD_BEEF);
    chk("R6 wrap idx", ctrl_rdata, 32'hC000_0000);
    wr_ctrl(32'h0000_007F);
    chk("R6 word127", data_rdata, 32'hDEAD_BEEF);

    // R7 R8 unaligned sequencer writes across a word boundary
    set_base(9'd5);
    busy = 1'b1;
    seq_pulse(1'b1, 8'hA1);
    seq_pulse(1'b1, 8'hA2);
    seq_pulse(1'b1, 8'hA3);
    seq_pulse(1'b1, 8'hA4);
    busy = 1'b0;
    wr_ctrl(32'h4000_0001);
    chk("R7 word1", data_rdata, 32'hA3A2_A122);
    rd_strobe();
    chk("R8 partial word2", data_rdata, 32'h3333_33A4);
    // R8 sequencer read back from offset
    busy = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R8 rbyte0", {24'h0, s_rbyte}, 32'hA1);
    seq_pulse(1'b0, 8'h00);
    chk("R8 rbyte1", {24'h0, s_rbyte}, 32'hA2);
    seq_pulse(1'b0, 8'h00);
    seq_pulse(1'b0, 8'h00);
    chk("R8 rbyte3", {24'h0, s_rbyte}, 32'hA4);

    // R9 host blocked while busy
    wr_ctrl(32'hC000_0000);
    wr_data(32'h5555_5555);
    chk("R9 busy idx", ctrl_rdata, 32'hC000_0000);
    busy = 1'b0;
    wr_ctrl(32'h4000_0000);
    chk("R9 busy word", data_rdata, 32'h1111_1111);
    // R9 sequencer write while idle is dropped
    set_base(9'd0);
    seq_pulse(1'b1, 8'h99);
    busy = 1'b1;
    @(negedge clk);
    chk("R9 idle seq", {24'h0, s_rbyte}, 32'h11);

    // R10 byte pointer wrap 511 -> 0
    set_base(9'd511);
    seq_pulse(1'b1, 8'h77);
    seq_pulse(1'b1, 8'h66);
    busy = 1'b0;
    wr_ctrl(32'h4000_007F);
    chk("R10 byte511", data_rdata, 32'h77AD_BEEF);
    rd_strobe();
    chk("R10 byte0", data_rdata, 32'h1111_1166);

    finish_run();
  end
endmodule